// File: doc/BRIEF.md
# Packet endpoint register interface

This block connects a processor's 16-bit register port to two word streams. On the outbound side, software writes header and payload words one at a time into a staging buffer. A flush command then hands the whole staged packet to a valid/ready output stream. On the inbound side, packets from a word stream are collected in a receive buffer. A packet becomes visible to software only after it has fully arrived and passed its checks. Software then pops it one word per read of a single data register. For each word, status flags show whether it is the first or last word of its packet and whether any word is waiting.

A packet starts with four header words: the destination, the source, a word whose low byte is the packet type and whose high byte is a block counter, and the payload length in bytes. On transmit, the hardware overwrites the counter byte with its own per-packet count. On receive, the block checks the header length against the actual stream length, checks that block counters keep increasing, and drops packets it cannot accept. The results appear as sticky status flags and as interrupt sources.

Back-pressure rules: the outbound stream holds `tx_valid`, `tx_data` and `tx_last` steady until `tx_ready` is seen. The inbound stream is never stalled: `rx_ready` is high whenever the block is out of reset, and a packet that cannot be stored is discarded rather than held back.

Top module: `pkt_endpoint`

## Requirements
- R1: `bus_sel` selects one of seven registers: 0 transmit word, 1 control, 2 receive word, 3 status, 4 local address, 5 remote address, 6 interrupt. Registers 4 and 5 read back what was last written. Register 0 reads as 0.
- R2: Each write to register 0 appends one word. A control write with bit 15 set sends the staged words, in order, on the outbound stream, with `tx_last` on the final word. A flush with nothing staged is ignored.
- R3: On the outbound stream, header word 2 leaves with its high byte replaced by a block counter. The counter is 0 after reset and advances by one for every packet sent. All other words pass unchanged.
- R4: Status bit 0 is set while words are staged but not yet sending. Bit 1 is set while sending. Bit 2 is set when the staging buffer is full. A word written while sending, or while the buffer is full, is discarded and sets sticky bit 3.
- R5: Control bit 12 enables reception and reads back; it is 0 after reset. Any control write loads it from bit 12 of the written data. A packet whose first word arrives while reception is off is dropped whole and sets sticky status bit 11.
- R6: Each read of register 2 returns the oldest stored word and removes it. Status bit 15 (word waiting), bit 13 (first of packet) and bit 12 (last of packet) describe the word the next read will return. A read with nothing waiting returns 0 and removes nothing.
- R7: A received packet is kept only if its word count equals 4 + floor((L+1)/2), where L is header word 3. Otherwise it is discarded and sticky bit 8 is set.
- R8: A received packet that does not fit in the free receive space is dropped whole and sets sticky bit 11. A packet that exactly fills the buffer is kept. A drop takes precedence over a length error.
- R9: When a packet is kept, its block counter (high byte of header word 2) is compared with that of the previous kept packet. If the difference, taken modulo 256, is 0 or at least 128, sticky bit 9 is set. The packet is still kept.
- R10: Status bits 3 to 11 are sticky. Writing 1 to a bit clears it, and writing back a value just read clears exactly the flags that were seen. A new event in the same cycle as a clear wins.
- R11: Register 6 reads four sources at bits 5 to 8: TX idle (live), packet sent (sticky), packet kept (sticky), and receive word waiting (live). A write to register 6 loads the enable mask from bits 5 to 8 and clears the sticky sources written as 1. `irq` is high when any enabled source is set.
- R12: `rx_ready` is high in every cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 3 | Register index |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops register 2) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register, valid in the same cycle |
| tx_valid | output | 1 | Outbound word valid |
| tx_ready | input | 1 | Outbound word accepted |
| tx_data | output | 16 | Outbound word |
| tx_last | output | 1 | Outbound final word of packet |
| rx_valid | input | 1 | Inbound word valid |
| rx_ready | output | 1 | Inbound ready, high after reset |
| rx_data | input | 16 | Inbound word |
| rx_last | input | 1 | Inbound final word of packet |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted receive pointer shows up at the next read of register 2 as a wrong word, or as first/last flags out of step with the packet boundaries. That read comes only a few cycles after the packet commits. A lost rewind after a rejected packet shows up one packet later: the rejected packet's words appear ahead of good data, or the buffer reports full too early. A wrong staging count or block counter is visible on the very next outbound packet as a wrong length, a misplaced `tx_last`, or a counter byte that does not follow the per-packet sequence. Sticky flags are compared against the expected set after every inbound packet, so a wrong set or clear shows up within one packet.

// File: rtl/pkt_ep_pkg.sv
package pkt_ep_pkg;
  localparam int WORD_W    = 16;
  localparam int SEL_W     = 3;
  localparam int HDR_WORDS = 4;
  localparam int CTR_WORD  = 2;   // header word whose high byte is the block counter
  localparam int LEN_WORD  = 3;   // header word holding the payload byte length

  typedef enum logic [SEL_W-1:0] {
    RG_TXDATA  = 3'd0,
    RG_TXCTRL  = 3'd1,
    RG_RXDATA  = 3'd2,
    RG_STATUS  = 3'd3,
    RG_DEVADDR = 3'd4,
    RG_TGTADDR = 3'd5,
    RG_IRQ     = 3'd6
  } reg_sel_e;

  // status word bit positions
  localparam int ST_BUILD     = 0;
  localparam int ST_SENDING   = 1;
  localparam int ST_TXFULL    = 2;
  localparam int ST_TXERR     = 3;
  localparam int ST_LENERR    = 8;
  localparam int ST_CTRERR    = 9;
  localparam int ST_DROP      = 11;
  localparam int ST_LAST      = 12;
  localparam int ST_FIRST     = 13;
  localparam int ST_AVAIL     = 15;
  localparam int ST_STICKY_LO = 3;
  localparam int ST_STICKY_HI = 11;

  // control word bits
  localparam int CT_RXEN  = 12;
  localparam int CT_FLUSH = 15;

  // interrupt word: four sources starting at this bit
  localparam int IQ_BASE = 5;
  localparam int IQ_SENT = 6;
  localparam int IQ_NEW  = 7;

  typedef struct packed {
    logic              first;
    logic              last;
    logic [WORD_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/pkt_ep_tx.sv
module pkt_ep_tx
  import pkt_ep_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              flush,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_last,
  output logic              building,
  output logic              sending,
  output logic              full,
  output logic              err_pulse,
  output logic              sent_pulse
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CW-1:0]     wcnt, rdi;
  logic [7:0]        blk_ctr;
  logic              sending_q;
  logic              accept, hs;
  logic [WORD_W-1:0] raw;

  assign full     = (wcnt == CW'(DEPTH));
  assign accept   = push && !sending_q && !full;
  assign hs       = sending_q && tx_ready;
  assign raw      = mem[rdi[AW-1:0]];
  assign tx_valid = sending_q;
  assign tx_last  = sending_q && (rdi == wcnt - CW'(1));
  assign tx_data  = (rdi == CW'(CTR_WORD)) ? {blk_ctr, raw[7:0]} : raw;

  assign building   = (wcnt != '0) && !sending_q;
  assign sending    = sending_q;
  assign err_pulse  = push && !accept;
  assign sent_pulse = hs && tx_last;

  always_ff @(posedge clk) begin
    if (accept) mem[wcnt[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt      <= '0;
      rdi       <= '0;
      sending_q <= 1'b0;
      blk_ctr   <= '0;
    end else begin
      if (accept) wcnt <= wcnt + CW'(1);
      if (flush && !sending_q && (wcnt != '0)) begin
        sending_q <= 1'b1;
        rdi       <= '0;
      end
      if (hs) begin
        if (tx_last) begin
          sending_q <= 1'b0;
          wcnt      <= '0;
          blk_ctr   <= blk_ctr + 8'd1;
        end else begin
          rdi <= rdi + CW'(1);
        end
      end
    end
  end

  // R2: an offered word stays put until taken
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R4: staging count never exceeds the buffer
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(DEPTH));

  // R4: a word pushed during sending leaves the staged count alone
  p_busy_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sending_q && push && !(tx_ready && tx_last) |=> $stable(wcnt));
endmodule

// File: rtl/pkt_ep_rx.sv
module pkt_ep_rx
  import pkt_ep_pkg::*;
#(
  parameter int DEPTH = 64   // power of two
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  input  logic              pop,
  output rx_entry_t         head,
  output logic              avail,
  output logic              drop_pulse,
  output logic              len_pulse,
  output logic              ctr_pulse,
  output logic              new_pulse
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW  = AW + 1;
  localparam int CNW = WORD_W + 1;

  function automatic logic [CNW-1:0] total_words(input logic [WORD_W-1:0] len);
    return CNW'(HDR_WORDS) + ((CNW'(len) + CNW'(1)) >> 1);
  endfunction

  rx_entry_t      mem [DEPTH];
  logic [PW-1:0]  rd_ptr, cm_ptr, wr_ptr;
  logic           in_pkt, dropping, have_prev;
  logic [CNW-1:0] cnt, exp_w, idx, exp_now;
  logic [7:0]     cap_ctr, prev_ctr, ctr_now, ctr_diff;
  logic           take, drop_cur, spec_full, drop_now, wr_word, len_ok, commit;
  rx_entry_t      ent;

  assign take      = rx_valid && rx_ready;
  assign idx       = in_pkt ? cnt : '0;
  assign drop_cur  = in_pkt ? dropping : !en;
  assign spec_full = ((wr_ptr - rd_ptr) == PW'(DEPTH));
  assign drop_now  = drop_cur || spec_full;
  assign wr_word   = take && !drop_now;
  assign exp_now   = (idx == CNW'(LEN_WORD)) ? total_words(rx_data) : exp_w;
  assign len_ok    = (idx >= CNW'(LEN_WORD)) && ((idx + CNW'(1)) == exp_now);
  assign ctr_now   = (idx == CNW'(CTR_WORD)) ? rx_data[WORD_W-1:8] : cap_ctr;
  assign ctr_diff  = ctr_now - prev_ctr;
  assign commit    = take && rx_last && !drop_now && len_ok;

  assign drop_pulse = take && rx_last && drop_now;
  assign len_pulse  = take && rx_last && !drop_now && !len_ok;
  assign new_pulse  = commit;
  assign ctr_pulse  = commit && have_prev && ((ctr_diff == 8'd0) || ctr_diff[7]);

  assign head  = mem[rd_ptr[AW-1:0]];
  assign avail = (cm_ptr != rd_ptr);

  always_comb begin
    ent.first = (idx == '0);
    ent.last  = rx_last;
    ent.data  = rx_data;
  end

  always_ff @(posedge clk) begin
    if (wr_word) mem[wr_ptr[AW-1:0]] <= ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready  <= 1'b0;
      rd_ptr    <= '0;
      cm_ptr    <= '0;
      wr_ptr    <= '0;
      in_pkt    <= 1'b0;
      dropping  <= 1'b0;
      cnt       <= '0;
      exp_w     <= '0;
      cap_ctr   <= '0;
      prev_ctr  <= '0;
      have_prev <= 1'b0;
    end else begin
      rx_ready <= 1'b1;
      if (take) begin
        in_pkt   <= !rx_last;
        dropping <= drop_now;
        cnt      <= (idx == {CNW{1'b1}}) ? idx : idx + CNW'(1);
        if (idx == CNW'(LEN_WORD)) exp_w <= exp_now;
        if (idx == CNW'(CTR_WORD)) cap_ctr <= rx_data[WORD_W-1:8];
        if (wr_word) wr_ptr <= wr_ptr + PW'(1);
        if (rx_last) begin
          if (commit) begin
            cm_ptr    <= wr_ptr + PW'(1);
            prev_ctr  <= ctr_now;
            have_prev <= 1'b1;
          end else begin
            wr_ptr <= cm_ptr;
          end
        end
      end
      if (pop && avail) rd_ptr <= rd_ptr + PW'(1);
    end
  end

  // R8: speculative writes never overrun unread words
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr - rd_ptr) <= PW'(DEPTH));

  // R6: readable words never run ahead of written words
  p_commit_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_ptr - rd_ptr) <= (wr_ptr - rd_ptr));

  // R6: a read with nothing waiting removes nothing
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !avail |=> $stable(rd_ptr));

  // R12: inbound side is always ready after reset
  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rx_ready);
endmodule

// File: rtl/pkt_endpoint.sv
module pkt_endpoint
  import pkt_ep_pkg::*;
#(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_last,
  output logic              irq
);
  logic                           rx_en, ev_sent, ev_new;
  logic [WORD_W-1:0]              dev_addr, tgt_addr;
  logic [3:0]                     irq_en, irq_src;
  logic [ST_STICKY_HI:ST_STICKY_LO] sticky;
  logic tx_push, tx_flush, rx_pop, wr_status, wr_irq;
  logic tx_building, tx_sending, tx_full, tx_err, tx_sent;
  logic rx_avail, rx_drop, rx_lenerr, rx_ctrerr, rx_new;
  rx_entry_t         rx_head;
  logic [WORD_W-1:0] set_vec, clr_vec, status_w;

  assign tx_push   = bus_wr && (bus_sel == RG_TXDATA);
  assign tx_flush  = bus_wr && (bus_sel == RG_TXCTRL) && bus_wdata[CT_FLUSH];
  assign rx_pop    = bus_rd && (bus_sel == RG_RXDATA);
  assign wr_status = bus_wr && (bus_sel == RG_STATUS);
  assign wr_irq    = bus_wr && (bus_sel == RG_IRQ);

  pkt_ep_tx #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(bus_wdata), .flush(tx_flush),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .building(tx_building), .sending(tx_sending), .full(tx_full),
    .err_pulse(tx_err), .sent_pulse(tx_sent)
  );

  pkt_ep_rx #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .pop(rx_pop), .head(rx_head), .avail(rx_avail),
    .drop_pulse(rx_drop), .len_pulse(rx_lenerr), .ctr_pulse(rx_ctrerr), .new_pulse(rx_new)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[ST_TXERR]  = tx_err;
    set_vec[ST_LENERR] = rx_lenerr;
    set_vec[ST_CTRERR] = rx_ctrerr;
    set_vec[ST_DROP]   = rx_drop;
  end
  assign clr_vec = wr_status ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      dev_addr <= '0;
      tgt_addr <= '0;
      irq_en   <= '0;
      sticky   <= '0;
      ev_sent  <= 1'b0;
      ev_new   <= 1'b0;
    end else begin
      if (bus_wr && (bus_sel == RG_TXCTRL)) rx_en <= bus_wdata[CT_RXEN];
      if (bus_wr && (bus_sel == RG_DEVADDR)) dev_addr <= bus_wdata;
      if (bus_wr && (bus_sel == RG_TGTADDR)) tgt_addr <= bus_wdata;
      if (wr_irq) irq_en <= bus_wdata[IQ_BASE +: 4];
      sticky  <= (sticky & ~clr_vec[ST_STICKY_HI:ST_STICKY_LO]) | set_vec[ST_STICKY_HI:ST_STICKY_LO];
      ev_sent <= (ev_sent && !(wr_irq && bus_wdata[IQ_SENT])) || tx_sent;
      ev_new  <= (ev_new && !(wr_irq && bus_wdata[IQ_NEW])) || rx_new;
    end
  end

  assign irq_src = {rx_avail, ev_new, ev_sent, !tx_sending};
  assign irq     = |(irq_en & irq_src);

  always_comb begin
    status_w                            = '0;
    status_w[ST_BUILD]                  = tx_building;
    status_w[ST_SENDING]                = tx_sending;
    status_w[ST_TXFULL]                 = tx_full;
    status_w[ST_STICKY_HI:ST_STICKY_LO] = sticky;
    status_w[ST_LAST]                   = rx_avail && rx_head.last;
    status_w[ST_FIRST]                  = rx_avail && rx_head.first;
    status_w[ST_AVAIL]                  = rx_avail;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      RG_TXCTRL:  bus_rdata[CT_RXEN] = rx_en;
      RG_RXDATA:  bus_rdata = rx_avail ? rx_head.data : '0;
      RG_STATUS:  bus_rdata = status_w;
      RG_DEVADDR: bus_rdata = dev_addr;
      RG_TGTADDR: bus_rdata = tgt_addr;
      RG_IRQ:     bus_rdata[IQ_BASE +: 4] = irq_src;
      default:    bus_rdata = '0;
    endcase
  end

  // R10: an all-ones clear with no new event empties every sticky flag
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status && (&bus_wdata[ST_STICKY_HI:ST_STICKY_LO]) && !(tx_err || rx_lenerr || rx_ctrerr || rx_drop)
    |=> sticky == '0);

  // R11: a sticky source written as 1 with no new event is cleared
  p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq && bus_wdata[IQ_NEW] && !rx_new |=> !ev_new);
endmodule

// File: tb/tb_pkt_endpoint.sv
module tb_pkt_endpoint;
  import pkt_ep_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 32;
  localparam int RXD = 64;

  logic        clk, rst_n;
  logic [2:0]  bus_sel;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        tx_valid, tx_ready, tx_last;
  logic [15:0] tx_data;
  logic        rx_valid, rx_ready, rx_last;
  logic [15:0] rx_data;
  logic        irq;

  pkt_endpoint #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit stall = 1'b0;

  logic [15:0] got_w[$];
  logic        got_l[$];
  logic [15:0] pkt[$];
  logic [15:0] txw[$];
  logic [17:0] exp_rx[$];
  logic [15:0] exp_sticky = '0;
  logic [7:0]  tx_ctr_m = '0;
  logic [7:0]  prev_m = '0;
  bit          have_prev_m = 1'b0;
  bit          rx_en_m = 1'b0;
  bit          ev_new_m = 1'b0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // outbound sink: choose ready at the falling edge, record what the next rising edge takes
  initial begin
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      tx_ready = stall ? 1'b0 : (($urandom % 4) != 0);
      if (tx_valid && tx_ready) begin
        got_w.push_back(tx_data);
        got_l.push_back(tx_last);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = a; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_sel = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  function automatic int pay_words(input int len);
    return (len + 1) / 2;
  endfunction

  task automatic build(input int len, input logic [7:0] ctr, input int adj);
    pkt = {};
    pkt.push_back(16'($urandom));
    pkt.push_back(16'($urandom));
    pkt.push_back({ctr, 8'($urandom)});
    pkt.push_back(16'(len));
    for (int i = 0; i < pay_words(len) + adj; i++) pkt.push_back(16'($urandom));
  endtask

  task automatic send_pkt();
    foreach (pkt[i]) begin
      @(negedge clk);
      if (($urandom % 3) == 0) begin rx_valid = 1'b0; @(negedge clk); end
      rx_valid = 1'b1; rx_data = pkt[i]; rx_last = (i == pkt.size() - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // reference model of one inbound packet
  task automatic model_rx();
    int n = pkt.size();
    logic [7:0] c, d;
    if (!rx_en_m || (exp_rx.size() + n > RXD)) exp_sticky[ST_DROP] = 1'b1;
    else if (n < 4 || n != 4 + pay_words(int'(pkt[3]))) exp_sticky[ST_LENERR] = 1'b1;
    else begin
      foreach (pkt[i]) exp_rx.push_back({i == 0, i == n - 1, pkt[i]});
      c = pkt[2][15:8];
      d = c - prev_m;
      if (have_prev_m && (d == 8'd0 || d[7])) exp_sticky[ST_CTRERR] = 1'b1;
      prev_m = c; have_prev_m = 1'b1; ev_new_m = 1'b1;
    end
  endtask

  task automatic rx_and_check(input string tag);
    logic [15:0] s;
    send_pkt();
    model_rx();
    rd(RG_STATUS, s);
    chk({tag, " R7 R8 R9 sticky flags"}, s & 16'h0FF8, exp_sticky & 16'h0FF8);
    wr(RG_STATUS, s);  // R10: write back what was seen
    exp_sticky = exp_sticky & ~s;
  endtask

  task automatic drain(input string tag);
    logic [15:0] s, v;
    while (exp_rx.size() > 0) begin
      logic [17:0] e = exp_rx.pop_front();
      rd(RG_STATUS, s);
      chk({tag, " R6 avail/first/last"}, {s[ST_AVAIL], s[ST_FIRST], s[ST_LAST]}, {1'b1, e[17], e[16]});
      rd(RG_RXDATA, v);
      chk({tag, " R6 popped word"}, v, e[15:0]);
    end
    rd(RG_STATUS, s);
    chk({tag, " R6 empty after drain"}, s[ST_AVAIL], 1'b0);
  endtask

  task automatic send_tx(input int n);
    txw = {};
    for (int i = 0; i < n; i++) begin
      txw.push_back(16'($urandom));
      wr(RG_TXDATA, txw[i]);
    end
  endtask

  task automatic flush_and_check(input string tag);
    int n = txw.size();
    logic [15:0] e;
    wr(RG_TXCTRL, 16'h8000 | (rx_en_m ? 16'h1000 : 16'h0));
    for (int k = 0; k < 4000 && got_w.size() < n; k++) @(negedge clk);
    chk({tag, " R2 word count"}, got_w.size(), n);
    for (int i = 0; i < n && got_w.size() > 0; i++) begin
      e = (i == CTR_WORD) ? {tx_ctr_m, txw[i][7:0]} : txw[i];
      chk({tag, (i == CTR_WORD) ? " R3 counter word" : " R2 word"}, got_w.pop_front(), e);
      chk({tag, " R2 last flag"}, got_l.pop_front(), (i == n - 1));
    end
    tx_ctr_m++;
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  ctr;
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_sel = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(RG_STATUS, v);  chk("R4 reset status", v, 16'h0000);
    rd(RG_TXCTRL, v);  chk("R5 reset rx enable", v, 16'h0000);
    rd(RG_IRQ, v);     chk("R11 reset irq sources", v, 16'h0020);
    chk("R11 reset irq pin", irq, 1'b0);
    chk("R12 rx_ready after reset", rx_ready, 1'b1);
    rd(RG_RXDATA, v);  chk("R6 empty read returns 0", v, 16'h0000);

    // R1 address registers
    wr(RG_DEVADDR, 16'h1234); wr(RG_TGTADDR, 16'hBEEF);
    rd(RG_DEVADDR, v); chk("R1 local address", v, 16'h1234);
    rd(RG_TGTADDR, v); chk("R1 remote address", v, 16'hBEEF);
    rd(RG_TXDATA, v);  chk("R1 transmit word reads 0", v, 16'h0000);

    // R2 R3 R4 outbound
    send_tx(6);
    rd(RG_STATUS, v); chk("R4 building flag", v[2:0], 3'b001);
    flush_and_check("tx6");
    rd(RG_IRQ, v);    chk("R11 sent event", v[IQ_SENT], 1'b1);
    wr(RG_IRQ, 16'h0040);
    rd(RG_IRQ, v);    chk("R11 sent event cleared", v[IQ_SENT], 1'b0);
    wr(RG_TXCTRL, 16'h8000); // empty flush ignored
    repeat (4) @(negedge clk);
    chk("R2 empty flush sends nothing", got_w.size(), 0);
    for (int p = 0; p < 6; p++) begin
      send_tx(1 + ($urandom % TXD));
      flush_and_check("txrand");
    end
    send_tx(TXD);
    rd(RG_STATUS, v); chk("R4 full flag", v[ST_TXFULL], 1'b1);
    wr(RG_TXDATA, 16'hDEAD);
    rd(RG_STATUS, v); chk("R4 write when full flags error", v[ST_TXERR], 1'b1);
    wr(RG_STATUS, v);
    flush_and_check("txfull");
    stall = 1'b1;
    send_tx(3);
    wr(RG_TXCTRL, 16'h8000);
    rd(RG_STATUS, v); chk("R4 sending flag", v[ST_SENDING], 1'b1);
    wr(RG_TXDATA, 16'hAAAA);
    rd(RG_STATUS, v); chk("R4 write while sending flags error", v[ST_TXERR], 1'b1);
    wr(RG_STATUS, v);
    stall = 1'b0;
    for (int k = 0; k < 4000 && got_w.size() < 3; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R4 discarded word not sent", got_w.size(), 3);
    for (int i = 0; i < 3 && got_w.size() > 0; i++) begin
      chk("R2 R3 stalled packet word", got_w.pop_front(), (i == CTR_WORD) ? {tx_ctr_m, txw[i][7:0]} : txw[i]);
      void'(got_l.pop_front());
    end
    tx_ctr_m++;

    // R5 reception disabled
    build(6, 8'd1, 0);
    rx_and_check("rxoff");
    rd(RG_STATUS, v); chk("R5 dropped packet not visible", v[ST_AVAIL], 1'b0);
    wr(RG_TXCTRL, 16'h1000); rx_en_m = 1'b1;
    rd(RG_TXCTRL, v); chk("R5 enable reads back", v, 16'h1000);

    // R11 interrupt on kept packet
    wr(RG_IRQ, 16'h0080); ev_new_m = 1'b0;
    chk("R11 irq quiet", irq, 1'b0);
    ctr = 8'd10;
    build(5, ctr, 0);
    rx_and_check("irq");
    chk("R11 irq on new packet", irq, 1'b1);
    wr(RG_IRQ, 16'h0080); ev_new_m = 1'b0;
    chk("R11 irq cleared", irq, 1'b0);
    drain("irq");

    // R7 length boundaries, R9 counter
    ctr++; build(0, ctr, 0); rx_and_check("len0");
    ctr++; build(1, ctr, 0); rx_and_check("len1");
    ctr++; build(9, ctr, 1); rx_and_check("toolong");
    ctr++; build(9, ctr, -1); rx_and_check("tooshort");
    pkt = {16'h1, 16'h2}; rx_and_check("runt");
    build(4, ctr, 0); rx_and_check("samectr");
    build(4, ctr - 8'd3, 0); rx_and_check("backctr");
    drain("len");

    // R8 full boundary
    for (int p = 0; p < 3; p++) begin ctr++; build(32, ctr, 0); rx_and_check("fill"); end
    ctr++; build(8, ctr, 0); rx_and_check("overfull");
    ctr++; build(0, ctr, 0); rx_and_check("exactfit");
    drain("full");

    // constrained random mix
    for (int p = 0; p < 40; p++) begin
      int adj = (($urandom % 5) == 0) ? ((($urandom % 2) == 0) ? 1 : -1) : 0;
      ctr = (($urandom % 6) == 0) ? ctr : ctr + 8'(1 + ($urandom % 3));
      build($urandom % 40, ctr, adj);
      rx_and_check("rand");
      if (($urandom % 3) == 0) drain("rand");
    end
    drain("final");

    summary();
  end
endmodule